// File: doc/BRIEF.md
# Capture/Compare Timer with Event Shortcuts

This block is a free-running up-counter with a bank of capture/compare channels. Counting is paced by a tick derived from the block clock, which is taken as the 16 MHz base rate, divided by a power of two chosen through a prescaler field. Single-cycle task pulses start, stop and zero the counter. A per-channel capture pulse copies the live count into that channel's register.

Each channel compares its register against the counter. When a tick moves the counter onto the stored value, the channel's event flag is raised. Per-channel shortcut bits can make that compare automatically zero the counter, which gives a periodic timer, or halt it, which gives a one-shot timer. Event flags are sticky. Interrupt enables have separate set and clear write addresses, and a single interrupt line is raised while any enabled channel holds its flag.

All registers are written through one write port. The address map is: 0 prescaler, 1 shortcuts, 2 interrupt set, 3 interrupt clear, 4 event flags, and 8+n for the value of channel n. Reads are replaced by direct outputs for the count, the channel values, the event flags and the run state.

Top module: `cc_timer`

## Requirements
- R1: After reset the timer is stopped, the count is 0, every channel value is 0, no event flag is set, the interrupt is low and the prescaler is 4, so the first count step comes 16 running cycles after start.
- R2: A start pulse sets the run state and a stop pulse clears it; when both arrive in the same cycle the timer stays stopped, and a stopped counter holds its value.
- R3: While running, the count rises by one every 2^p clock cycles, where p is the prescaler value written at address 0 (0 to 9); a write of a value above 9 is dropped.
- R4: A prescaler write made while the timer runs is ignored, and the rate in use is kept.
- R5: A clear pulse sets the count to 0 on the next edge, even when a count step falls in the same cycle.
- R6: A capture pulse on channel n loads the count present in that cycle into channel n; it overrides a register write to address 8+n in the same cycle.
- R7: When a count step moves the counter onto channel n's value, event flag n is set on that same edge; the flag stays set until a write to address 4 has bit n equal to 0, and a write with bit n equal to 1 leaves it unchanged.
- R8: With shortcut bit n (address 1) set, a compare on channel n loads the counter with 0 instead of the matched value, so the count repeats with a period equal to the channel value in ticks.
- R9: With shortcut bit 8+n set, a compare on channel n stops the timer and the count holds the matched value.
- R10: Writing 1 to bit 16+n at address 2 enables the interrupt of channel n and writing 1 to that bit at address 3 disables it, zeros have no effect; the interrupt is the OR over channels of flag AND enable, and disabling does not clear a flag.
- R11: After the largest count value the counter wraps to 0, and a channel holding 0 raises its event flag on the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, one cycle per undivided tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| task_start | input | 1 | Pulse that sets the run state |
| task_stop | input | 1 | Pulse that clears the run state |
| task_clear | input | 1 | Pulse that zeros the counter and the divider |
| task_capture | input | NUM_CH | Per-channel pulse that copies the count into the channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Run state |
| cc_o | output | NUM_CH*CNT_W | Channel values, channel n at bits n*CNT_W upward |
| evt_o | output | NUM_CH | Sticky compare event flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
A divider that slips by one cycle shows up as a wrong count only after a full prescaled period, so the runs span many periods and compare the final count with the cycle total divided by 2^p. A stale shortcut or enable bit shows at the ports on the very next compare or flag change: the count fails to fold back to zero, the run state fails to drop, or the interrupt line follows the wrong channel. A flag that clears itself goes unseen until the next write to the flag address, so the flags are read back both before and after writes that carry ones.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int ADDR_W = 4;
    localparam int PSC_W = 4;
    localparam int PSC_MAX = 9;
    localparam int PSC_RST = 4;
    localparam int DIV_W = PSC_MAX;
    localparam int STOP_BASE = 8;
    localparam int INT_BASE = 16;

    localparam logic [ADDR_W-1:0] ADR_PSC    = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_SHORTS = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_INTSET = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_INTCLR = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_EVT    = 4'h4;
    localparam logic [ADDR_W-1:0] ADR_CC0    = 4'h8;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler import cct_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] psc_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_t;

    div_t s_d, s_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        s_d    = s_q;
        // shifting past the width yields zero, so the mask becomes all ones
        mask   = (DIV_W'(1) << psc_i) - DIV_W'(1);
        tick_o = run_i && ((s_q.div & mask) == mask);
        if (!run_i || restart_i) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    input  logic             cap_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             evt_clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] cc_o,
    output logic             evt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cc;
        logic             evt;
    } ch_t;

    ch_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        hit_o = tick_i && !clear_i && (cnt_next_i == s_q.cc);
        if (cap_i) begin
            s_d.cc = cnt_i;
        end else if (wr_i) begin
            s_d.cc = wdata_i;
        end
        if (hit_o) begin
            s_d.evt = 1'b1;
        end else if (evt_clr_i) begin
            s_d.evt = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cc_o  = s_q.cc;
    assign evt_o = s_q.evt;
endmodule

// File: rtl/cc_timer.sv
module cc_timer import cct_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    task_start,
    input  logic                    task_stop,
    input  logic                    task_clear,
    input  logic [NUM_CH-1:0]       task_capture,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [CNT_W-1:0]        count_o,
    output logic                    running_o,
    output logic [NUM_CH*CNT_W-1:0] cc_o,
    output logic [NUM_CH-1:0]       evt_o,
    output logic                    irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              run;
        logic [PSC_W-1:0]  psc;
        logic [NUM_CH-1:0] sh_clr;
        logic [NUM_CH-1:0] sh_stop;
        logic [NUM_CH-1:0] ien;
    } tmr_t;

    tmr_t              s_d, s_q;
    logic              tick;
    logic [CNT_W-1:0]  cnt_inc;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] cc_we;
    logic [NUM_CH-1:0] evt_clr;

    assign cnt_inc = s_q.cnt + CNT_W'(1);

    cct_prescaler u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (s_q.run),
        .restart_i (task_clear),
        .psc_i     (s_q.psc),
        .tick_o    (tick)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign cc_we[n]   = reg_we && (reg_addr == ADR_CC0 + ADDR_W'(n));
        assign evt_clr[n] = reg_we && (reg_addr == ADR_EVT) && !reg_wdata[n];

        cct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick),
            .clear_i    (task_clear),
            .cap_i      (task_capture[n]),
            .wr_i       (cc_we[n]),
            .wdata_i    (reg_wdata[CNT_W-1:0]),
            .evt_clr_i  (evt_clr[n]),
            .cnt_i      (s_q.cnt),
            .cnt_next_i (cnt_inc),
            .hit_o      (hit[n]),
            .cc_o       (cc_o[n*CNT_W +: CNT_W]),
            .evt_o      (evt_o[n])
        );
    end

    always_comb begin
        s_d = s_q;
        // counter: clear task or clear shortcut beat the count step
        if (task_clear || |(hit & s_q.sh_clr)) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = cnt_inc;
        end
        // run state: any stop source beats start
        if (task_stop || |(hit & s_q.sh_stop)) begin
            s_d.run = 1'b0;
        end else if (task_start) begin
            s_d.run = 1'b1;
        end
        if (reg_we && reg_addr == ADR_PSC && !s_q.run && reg_wdata <= 32'(PSC_MAX)) begin
            s_d.psc = reg_wdata[PSC_W-1:0];
        end
        if (reg_we && reg_addr == ADR_SHORTS) begin
            s_d.sh_clr  = reg_wdata[NUM_CH-1:0];
            s_d.sh_stop = reg_wdata[STOP_BASE +: NUM_CH];
        end
        if (reg_we && reg_addr == ADR_INTSET) begin
            s_d.ien = s_q.ien | reg_wdata[INT_BASE +: NUM_CH];
        end
        if (reg_we && reg_addr == ADR_INTCLR) begin
            s_d.ien = s_q.ien & ~reg_wdata[INT_BASE +: NUM_CH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.psc <= PSC_W'(PSC_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o   = s_q.cnt;
    assign running_o = s_q.run;
    assign irq_o     = |(evt_o & s_q.ien);
endmodule

// File: rtl/cct_checker.sv
module cct_checker import cct_pkg::*; #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    task_start,
    input logic                    task_stop,
    input logic                    task_clear,
    input logic [NUM_CH-1:0]       task_capture,
    input logic                    reg_we,
    input logic [ADDR_W-1:0]       reg_addr,
    input logic [31:0]             reg_wdata,
    input logic [CNT_W-1:0]        count_o,
    input logic                    running_o,
    input logic [NUM_CH*CNT_W-1:0] cc_o,
    input logic [NUM_CH-1:0]       evt_o,
    input logic                    irq_o
);
    p_stop_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        task_stop |=> !running_o);

    p_hold_when_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_o && !task_clear) |=> $stable(count_o));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        task_clear |=> count_o == '0);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_cap
        p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
            task_capture[n] |=> cc_o[n*CNT_W +: CNT_W] == $past(count_o));

        p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_o[n] && !(reg_we && reg_addr == ADR_EVT && !reg_wdata[n])) |=> evt_o[n]);
    end

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (evt_o != '0));
endmodule

bind cc_timer cct_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_start   (task_start),
    .task_stop    (task_stop),
    .task_clear   (task_clear),
    .task_capture (task_capture),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .count_o      (count_o),
    .running_o    (running_o),
    .cc_o         (cc_o),
    .evt_o        (evt_o),
    .irq_o        (irq_o)
);

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
    localparam int NUM_CH = 4;
    localparam int CNT_W  = 32;
    localparam int W_SM   = 8;
    localparam int NVEC   = 6;
    // {prescaler, running cycles, expected count}
    localparam int VEC [NVEC][3] = '{
        '{0, 10, 10}, '{1, 21, 10}, '{2, 41, 10},
        '{3, 16, 2},  '{9, 1100, 2}, '{5, 31, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic task_start = 1'b0, task_stop = 1'b0, task_clear = 1'b0;
    logic [NUM_CH-1:0] task_capture = '0;
    logic reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [CNT_W-1:0] count_o;
    logic running_o, irq_o;
    logic [NUM_CH*CNT_W-1:0] cc_o;
    logic [NUM_CH-1:0] evt_o;
    logic [W_SM-1:0] count_w;
    logic running_w, irq_w;
    logic [NUM_CH*W_SM-1:0] cc_w;
    logic [NUM_CH-1:0] evt_w;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cc_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
        .task_clear(task_clear), .task_capture(task_capture), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count_o(count_o),
        .running_o(running_o), .cc_o(cc_o), .evt_o(evt_o), .irq_o(irq_o));

    cc_timer #(.NUM_CH(NUM_CH), .CNT_W(W_SM)) dut_w (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
        .task_clear(task_clear), .task_capture(task_capture), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .count_o(count_w),
        .running_o(running_w), .cc_o(cc_w), .evt_o(evt_w), .irq_o(irq_w));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all helpers start and end at a falling edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic p_start();
        task_start = 1'b1; @(negedge clk); task_start = 1'b0;
    endtask

    task automatic p_stop();
        task_stop = 1'b1; @(negedge clk); task_stop = 1'b0;
    endtask

    task automatic p_clear();
        task_clear = 1'b1; @(negedge clk); task_clear = 1'b0;
    endtask

    task automatic run_for(input int m);
        p_start();
        repeat (m - 1) @(negedge clk);
        p_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 count", count_o, 0);
        check("R1 running", running_o, 0);
        check("R1 cc", (cc_o == '0), 1);
        check("R1 evt", evt_o, 0);
        check("R1 irq", irq_o, 0);
        run_for(48);
        check("R1 default prescaler", count_o, 3);

        // R3: table of prescaler settings
        for (int v = 0; v < NVEC; v++) begin
            wr(4'h0, 32'(VEC[v][0]));
            p_clear();
            run_for(VEC[v][1]);
            check("R3 rate", count_o, VEC[v][2]);
        end

        // R3: out-of-range prescaler dropped
        wr(4'h0, 32'd2);
        wr(4'h0, 32'd10);
        p_clear();
        run_for(8);
        check("R3 value above 9 dropped", count_o, 2);

        // R4: prescaler write while running ignored
        wr(4'h0, 32'd0);
        p_clear();
        p_start();
        wr(4'h0, 32'd5);
        p_stop();
        check("R4 run with write", count_o, 2);
        p_clear();
        run_for(5);
        check("R4 rate kept", count_o, 5);

        // R5: clear beats a count step
        p_clear();
        p_start();
        repeat (3) @(negedge clk);
        check("R5 before clear", count_o, 3);
        p_clear();
        check("R5 clear wins", count_o, 0);
        p_stop();
        check("R5 count resumes", count_o, 1);

        // R6: capture overrides write
        p_clear();
        run_for(7);
        task_capture = 4'b0010;
        wr(4'h9, 32'd99);
        task_capture = '0;
        check("R6 capture ch1", cc_o[1*CNT_W +: CNT_W], 7);
        check("R6 ch0 untouched", cc_o[0 +: CNT_W], 0);

        // R7: compare flags
        wr(4'h8, 32'd5);
        p_clear();
        run_for(10);
        check("R7 count", count_o, 10);
        check("R7 flags set", evt_o, 4'b0011);
        wr(4'h4, 32'hFFFF_FFFF);
        check("R7 ones leave flags", evt_o, 4'b0011);
        wr(4'h4, 32'hFFFF_FFFE);
        check("R7 zero clears flag", evt_o, 4'b0010);

        // R10: interrupt enables
        check("R10 irq off", irq_o, 0);
        wr(4'h2, 32'h0002_0000);
        check("R10 irq set", irq_o, 1);
        wr(4'h2, 32'h0);
        wr(4'h3, 32'h0);
        check("R10 zero writes", irq_o, 1);
        wr(4'h3, 32'h0002_0000);
        check("R10 irq cleared", irq_o, 0);
        check("R10 flag kept", evt_o, 4'b0010);
        wr(4'h2, 32'h0001_0000);
        check("R10 enable without flag", irq_o, 0);
        wr(4'h4, 32'h0);
        wr(4'h3, 32'hFFFF_FFFF);

        // R8: clear shortcut
        wr(4'h1, 32'h0000_0001);
        p_clear();
        run_for(12);
        check("R8 periodic count", count_o, 2);
        check("R8 flags", evt_o, 4'b0001);
        wr(4'h1, 32'h0);
        wr(4'h4, 32'h0);

        // R9: stop shortcut
        wr(4'h1, 32'h0000_0100);
        p_clear();
        p_start();
        repeat (20) @(negedge clk);
        check("R9 stopped", running_o, 0);
        check("R9 count held", count_o, 5);
        wr(4'h1, 32'h0);
        wr(4'h4, 32'h0);

        // R2: start and stop together
        task_start = 1'b1; task_stop = 1'b1;
        @(negedge clk);
        task_start = 1'b0; task_stop = 1'b0;
        check("R2 stop wins", running_o, 0);
        p_start();
        check("R2 running", running_o, 1);
        p_stop();
        check("R2 stopped", running_o, 0);

        // R11: wrap on the narrow instance
        do_reset();
        wr(4'h0, 32'd0);
        p_clear();
        run_for(258);
        check("R11 wrap count", count_w, 2);
        check("R11 zero compare on wrap", evt_w, 4'b1111);
        check("R11 wide count", count_o, 258);
        check("R11 wide no flags", evt_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule